// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two Separate-I/O SRAM Core

This block is a synthesizable behavioural model of a synchronous SRAM. It has separate data-in and data-out buses, and every access is a burst of two beats. A read and a write can both be requested in the same clock cycle, because the read port and the write port are independent. The model runs on one rising-edge clock at twice the interface rate. An internal phase state machine tells the two slots apart. The PH_RISE slot stands for the rising edge of the interface clock and the PH_FALL slot stands for the falling edge. The machine leaves reset in PH_RISE and moves PH_RISE→PH_FALL→PH_RISE on every fast cycle. The current slot is brought out on `k_rise`.

Commands and addresses are taken only in a PH_RISE slot.

- **Write.** The first write beat and its byte enables are captured in the same PH_RISE slot as the command. The second beat and its enables are taken in the PH_FALL slot that follows. At the end of that PH_FALL slot the two beats are merged into a double-width word and written to the array in one operation.
- **Read.** In the same PH_FALL slot the core fetches one double-width word for a pending read. If the write being completed targets the same address, the freshly merged word is forwarded. The word then passes through a latency pipeline into an output serializer with two states, SER_IDLE and SER_HI. SER_IDLE→SER_HI happens when a fetched word arrives and the low half is driven. SER_HI→SER_IDLE happens after the high half is driven, unless another word arrives at that point.

Top module: `qdr_b2_sram_core`

## Requirements
- R1: In the first fast cycle after reset is released, `k_rise` is 1. After that it toggles every fast cycle: 1 marks a PH_RISE slot and 0 marks a PH_FALL slot.
- R2: `rd_n`, `wr_n` and both address buses are sampled only in PH_RISE slots. Asserting `rd_n=0` or `wr_n=0` in a PH_FALL slot starts no read and changes no stored word.
- R3: A write (`wr_n=0` in a PH_RISE slot) stores the `d` of that slot as bits [DW-1:0] of the word. It stores the `d` of the following PH_FALL slot as bits [2*DW-1:DW].
- R4: Each beat carries its own active-low byte enables on `bw_n`. `bw_n[i]=0` writes bits [8i+7:8i] of that beat. `bw_n[i]=1` leaves that byte of the stored word unchanged.
- R5: A read issued in the PH_RISE slot of fast cycle T drives the low half of the word on `q` in cycle T+5, which is a PH_FALL slot. It drives the high half in cycle T+6. This is 2.5 interface cycles.
- R6: `q_valid` is 1 exactly in the fast cycles that carry read data. In all other cycles `q` is 0.
- R7: A read and a write to different addresses can be issued in the same PH_RISE slot, and can be issued in every consecutive PH_RISE slot. With reads back to back, `q_valid` stays 1 without a gap.
- R8: A read returns the stored word as changed by every write issued in the same or an earlier PH_RISE slot. This includes a partially masked write to the same address in the same slot. A read is not affected by writes issued in later slots.
- R9: During reset `q_valid` and `q` are 0. The array contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two slots per interface cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read request (PH_RISE slot) |
| rd_addr | input | AW | Read word address |
| wr_n | input | 1 | Active-low write request (PH_RISE slot) |
| wr_addr | input | AW | Write word address |
| d | input | DW | Write data beat |
| bw_n | input | DW/8 | Active-low byte enables for the current beat |
| k_rise | output | 1 | 1 in PH_RISE slots, 0 in PH_FALL slots |
| q | output | DW | Read data beat |
| q_valid | output | 1 | Read data present on `q` |

## Verification
The assertions check the slot alternation on every cycle. They also check that every read command is followed five cycles later by a two-beat valid window that starts in a PH_FALL slot, that cycles with no read produce no valid beat, and that `q` is zero outside valid beats.

Only the bench's scenarios can show the data itself. It compares against a reference array and covers the following cases:

- byte-masked merging across both beats;
- forwarding for a write to the same address in the same slot;
- reads that must return older data even though a write to the same address follows in the next slot;
- that requests made in PH_FALL slots leave the array untouched.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    typedef enum logic { PH_RISE = 1'b0, PH_FALL = 1'b1 } phase_e;
    typedef enum logic { SER_IDLE = 1'b0, SER_HI = 1'b1 } ser_e;
endpackage

// File: rtl/qdr_phase_fsm.sv
module qdr_phase_fsm
    import qdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic k_rise
);
    phase_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_RISE;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            PH_RISE: state_n = PH_FALL;
            PH_FALL: state_n = PH_RISE;
            default: state_n = PH_RISE;
        endcase
    end

    always_comb begin
        k_rise = (state_q == PH_RISE);
    end
endmodule

// File: rtl/qdr_cmd_capture.sv
module qdr_cmd_capture #(
    parameter int DW = 16,
    parameter int AW = 4,
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             k_rise,
    input  logic             rd_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_n,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    d,
    input  logic [LANES-1:0] bw_n,
    output logic             rd_pend,
    output logic [AW-1:0]    ra_q,
    output logic             wr_pend,
    output logic [AW-1:0]    wa_q,
    output logic [DW-1:0]    d0_q,
    output logic [LANES-1:0] bw0_q
);
    // pend flags are high only during the PH_FALL slot after a command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            rd_pend <= k_rise && !rd_n;
            wr_pend <= k_rise && !wr_n;
        end
    end

    always_ff @(posedge clk) begin
        if (k_rise) begin
            ra_q  <= rd_addr;
            wa_q  <= wr_addr;
            d0_q  <= d;
            bw0_q <= bw_n;
        end
    end
endmodule

// File: rtl/qdr_word_store.sv
module qdr_word_store #(
    parameter int DW = 16,
    parameter int AW = 4,
    localparam int LANES = DW / 8,
    localparam int WW    = 2 * DW,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pend,
    input  logic [AW-1:0]    wa,
    input  logic [DW-1:0]    d0,
    input  logic [LANES-1:0] bw0_n,
    input  logic [DW-1:0]    d1,
    input  logic [LANES-1:0] bw1_n,
    input  logic             rd_pend,
    input  logic [AW-1:0]    ra,
    output logic [WW-1:0]    rd_word,
    output logic             rd_vld
);
    logic [WW-1:0] mem [DEPTH];
    logic [WW-1:0] merged;

    always_comb begin
        merged = mem[wa];
        for (int l = 0; l < LANES; l++) begin
            if (!bw0_n[l]) merged[l*8 +: 8]      = d0[l*8 +: 8];
            if (!bw1_n[l]) merged[DW + l*8 +: 8] = d1[l*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_pend) mem[wa] <= merged;
    end

    // fetch with forwarding of the write completing in this slot
    always_ff @(posedge clk) begin
        if (rd_pend) begin
            if (wr_pend && (wa == ra)) rd_word <= merged;
            else                       rd_word <= mem[ra];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= rd_pend;
    end
endmodule

// File: rtl/qdr_rd_serializer.sv
module qdr_rd_serializer
    import qdr_pkg::*;
#(
    parameter int DW      = 16,
    parameter int RD_PIPE = 2,
    localparam int WW     = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [WW-1:0] in_word,
    output logic [DW-1:0] q,
    output logic          q_valid
);
    logic [WW-1:0]      pw [RD_PIPE+1];
    logic [RD_PIPE:0]   pv;
    logic [DW-1:0]      hi_q;
    logic               last_v;
    logic [WW-1:0]      last_w;
    ser_e               state_q, state_n;

    assign pw[0] = in_word;
    assign pv[0] = in_vld;

    for (genvar g = 0; g < RD_PIPE; g++) begin : g_stage
        always_ff @(posedge clk) begin
            pw[g+1] <= pw[g];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pv[g+1] <= 1'b0;
            else        pv[g+1] <= pv[g];
        end
    end

    assign last_v = pv[RD_PIPE];
    assign last_w = pw[RD_PIPE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            SER_IDLE: state_n = last_v ? SER_HI : SER_IDLE;
            SER_HI:   state_n = last_v ? SER_HI : SER_IDLE;
            default:  state_n = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
            hi_q    <= '0;
        end else if (last_v) begin
            q       <= last_w[DW-1:0];
            q_valid <= 1'b1;
            hi_q    <= last_w[WW-1:DW];
        end else if (state_q == SER_HI) begin
            q       <= hi_q;
            q_valid <= 1'b1;
        end else begin
            q       <= '0;
            q_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/qdr_b2_sram_core.sv
module qdr_b2_sram_core #(
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int RD_PIPE = 2,
    localparam int LANES  = DW / 8,
    localparam int WW     = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_n,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    d,
    input  logic [LANES-1:0] bw_n,
    output logic             k_rise,
    output logic [DW-1:0]    q,
    output logic             q_valid
);
    logic             rd_pend, wr_pend, rd_vld;
    logic [AW-1:0]    ra_q, wa_q;
    logic [DW-1:0]    d0_q;
    logic [LANES-1:0] bw0_q;
    logic [WW-1:0]    rd_word;

    qdr_phase_fsm u_phase (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise)
    );

    qdr_cmd_capture #(.DW(DW), .AW(AW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .k_rise(k_rise),
        .rd_n(rd_n), .rd_addr(rd_addr), .wr_n(wr_n), .wr_addr(wr_addr),
        .d(d), .bw_n(bw_n),
        .rd_pend(rd_pend), .ra_q(ra_q), .wr_pend(wr_pend), .wa_q(wa_q),
        .d0_q(d0_q), .bw0_q(bw0_q)
    );

    qdr_word_store #(.DW(DW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_pend(wr_pend), .wa(wa_q),
        .d0(d0_q), .bw0_n(bw0_q), .d1(d), .bw1_n(bw_n),
        .rd_pend(rd_pend), .ra(ra_q), .rd_word(rd_word), .rd_vld(rd_vld)
    );

    qdr_rd_serializer #(.DW(DW), .RD_PIPE(RD_PIPE)) u_ser (
        .clk(clk), .rst_n(rst_n), .in_vld(rd_vld), .in_word(rd_word),
        .q(q), .q_valid(q_valid)
    );
endmodule

// File: rtl/qdr_b2_sram_core_chk.sv
module qdr_b2_sram_core_chk #(
    parameter int DW = 16,
    parameter int AW = 4,
    localparam int LANES = DW / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_n,
    input logic [AW-1:0]    rd_addr,
    input logic             wr_n,
    input logic [AW-1:0]    wr_addr,
    input logic [DW-1:0]    d,
    input logic [LANES-1:0] bw_n,
    input logic             k_rise,
    input logic [DW-1:0]    q,
    input logic             q_valid
);
    p_phase_alt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        k_rise |=> !k_rise);

    p_phase_ret_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !k_rise |=> k_rise);

    p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_rise && !rd_n) |-> ##5 (q_valid && !k_rise) ##1 q_valid);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (k_rise && rd_n) |-> ##5 !q_valid);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q == '0));
endmodule

bind qdr_b2_sram_core qdr_b2_sram_core_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
    .wr_n(wr_n), .wr_addr(wr_addr), .d(d), .bw_n(bw_n),
    .k_rise(k_rise), .q(q), .q_valid(q_valid)
);

// File: tb/qdr_b2_sram_core_tb_top.sv
`timescale 1ns/1ps
module qdr_b2_sram_core_tb_top;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [DW-1:0] d = '0;
    logic [1:0]    bw_n = 2'b11;
    logic          k_rise;
    logic [DW-1:0] q;
    logic          q_valid;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rel = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    logic [2*DW-1:0] ref_mem [NW];
    bit              exp_v [64];
    logic [DW-1:0]   exp_q [64];
    string           exp_t [64];

    always #4 clk = ~clk;

    qdr_b2_sram_core #(.DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .d(d), .bw_n(bw_n),
        .k_rise(k_rise), .q(q), .q_valid(q_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // per-cycle comparison against the behavioural reference
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (q_valid !== 1'b0 || q !== '0) begin
                errors++;
                $display("FAIL R9 reset: q_valid=%b q=%h expected 0/0", q_valid, q);
            end
        end else if (started && !done) begin
            automatic int idx = cyc % 64;
            automatic bit ek = ((cyc - rel) % 2) == 0;
            checks++;
            if (k_rise !== ek) begin
                errors++;
                $display("FAIL R1 cycle %0d: k_rise=%b expected %b", cyc, k_rise, ek);
            end
            checks++;
            if (q_valid !== exp_v[idx]) begin
                errors++;
                $display("FAIL R6 cycle %0d: q_valid=%b expected %b", cyc, q_valid, exp_v[idx]);
            end else if (exp_v[idx]) begin
                checks++;
                if (q !== exp_q[idx]) begin
                    errors++;
                    $display("FAIL %s cycle %0d: q=%h expected %h", exp_t[idx], cyc, q, exp_q[idx]);
                end
            end else begin
                checks++;
                if (q !== '0) begin
                    errors++;
                    $display("FAIL R6 cycle %0d: idle q=%h expected 0", cyc, q);
                end
            end
            exp_v[idx] = 1'b0;
        end
    end

    function automatic logic [DW-1:0] mrg(logic [DW-1:0] old, logic [DW-1:0] nw, logic [1:0] b);
        logic [DW-1:0] r = old;
        for (int l = 0; l < 2; l++) if (!b[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    // one PH_RISE slot plus the following PH_FALL slot
    task automatic slot(input bit rd, input int ra, input bit wr, input int wa,
                        input logic [DW-1:0] d0, input logic [1:0] b0,
                        input logic [DW-1:0] d1, input logic [1:0] b1,
                        input bit ghost, input string tag);
        int t;
        logic [2*DW-1:0] e;
        @(posedge clk); #1;
        if (!k_rise) begin @(posedge clk); #1; end
        t = cyc;
        rd_n = !rd; wr_n = !wr;
        rd_addr = AW'(ra); wr_addr = AW'(wa);
        d = d0; bw_n = b0;
        if (wr) begin
            ref_mem[wa][DW-1:0]    = mrg(ref_mem[wa][DW-1:0], d0, b0);
            ref_mem[wa][2*DW-1:DW] = mrg(ref_mem[wa][2*DW-1:DW], d1, b1);
        end
        if (rd) begin
            e = ref_mem[ra];
            exp_v[(t+5)%64] = 1'b1; exp_q[(t+5)%64] = e[DW-1:0];    exp_t[(t+5)%64] = tag;
            exp_v[(t+6)%64] = 1'b1; exp_q[(t+6)%64] = e[2*DW-1:DW]; exp_t[(t+6)%64] = tag;
        end
        @(posedge clk); #1;
        d = d1; bw_n = b1;
        if (ghost) begin
            rd_n = 1'b0; wr_n = 1'b0;
            rd_addr = AW'($urandom); wr_addr = AW'($urandom);
        end else begin
            rd_n = 1'b1; wr_n = 1'b1;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rel = cyc;
        started = 1'b1;

        // R3: fill every word with full-mask two-beat writes
        for (int a = 0; a < NW; a++)
            slot(0, 0, 1, a, DW'($urandom), 2'b00, DW'($urandom), 2'b00, 0, "R3");

        // R7/R5: back-to-back reads with simultaneous writes elsewhere
        for (int a = 0; a < NW; a++)
            slot(1, a, 1, (a + 8) % NW, DW'($urandom), 2'b00, DW'($urandom), 2'b00, 0, "R7");

        // R4/R8: read and masked write to the same word in one slot
        for (int m = 0; m < 16; m++)
            slot(1, m, 1, m, DW'($urandom), m[1:0], DW'($urandom), m[3:2], 0, "R8");

        // R8: write then read the same word in the next slot
        slot(0, 0, 1, 3, 16'hA5A5, 2'b10, 16'h5A5A, 2'b01, 0, "R4");
        slot(1, 3, 0, 0, 16'h0, 2'b11, 16'h0, 2'b11, 0, "R8");

        // R8: read followed by a write to that word returns old data
        slot(1, 5, 0, 0, 16'h0, 2'b11, 16'h0, 2'b11, 0, "R8");
        slot(0, 0, 1, 5, 16'hFFFF, 2'b00, 16'hEEEE, 2'b00, 0, "R8");
        slot(1, 5, 0, 0, 16'h0, 2'b11, 16'h0, 2'b11, 0, "R8");

        // R2: requests in PH_FALL slots are ignored
        for (int k = 0; k < 6; k++)
            slot(0, 0, 0, 0, DW'($urandom), 2'b00, DW'($urandom), 2'b00, 1, "R2");
        for (int a = 0; a < NW; a++)
            slot(1, a, 0, 0, 16'h0, 2'b11, 16'h0, 2'b11, 1, "R2");

        // R5/R7/R8: random traffic with random masks
        for (int k = 0; k < 300; k++)
            slot($urandom % 2, $urandom % NW, $urandom % 2, $urandom % NW,
                 DW'($urandom), 2'($urandom), DW'($urandom), 2'($urandom), 0, "R5");

        for (int k = 0; k < 8; k++)
            slot(0, 0, 0, 0, 16'h0, 2'b11, 16'h0, 2'b11, 0, "R6");
        repeat (4) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule